// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock-Loss Flags

This block is a sampled model of a tri-state phase-frequency detector, clocked by a single fast system clock. It takes a reference clock and a feedback clock as plain level inputs, resynchronises both, and finds their rising edges. A reference edge raises an UP pulse and a feedback edge raises a DN pulse. As soon as both are pending they are cleared together, so each pulse lasts as long as the two edges are apart.

Two lock-loss flags come from the same pulses. The feedback-too-fast flag is refreshed on every feedback edge with the value DN held just before that edge. A second feedback edge arriving before any reference edge therefore sets the flag. The reference-too-fast flag is refreshed a programmable number of system cycles after each reference edge with the value of UP at that moment. It goes high only when UP outlives that window. The window is set wide enough that the ordinary phase error of a locked loop never raises a flag. Neither flag is sticky. Each sample overwrites it, and it holds its value between samples.

Top module: `pfd_lockwatch`

## Requirements
- R1: While the synchronous active-high reset is high, and on the first cycle after it, `up`, `dn`, `ref_fast` and `fb_fast` are all 0, and the window counter is idle.
- R2: Each input passes through two synchronising flops and an edge register. A rising level on `ref_in` with no pending DN sets `up` on the third rising clock edge after the change. A rising level on `fb_in` with no pending UP sets `dn` the same way.
- R3: `up` and `dn` are never high together. When one is pending and the other edge is detected, both read 0 from the next cycle on. The UP pulse width in cycles therefore equals the reference-to-feedback edge distance.
- R4: Reference and feedback edges detected in the same cycle, with nothing pending, leave `up` and `dn` low.
- R5: On each detected feedback edge, `fb_fast` takes the value `dn` had in that cycle.
- R6: For `win` = N > 0, `ref_fast` takes the value of `up` N cycles after the reference edge detection. For `win` = 0 it samples `up` in the detection cycle itself. A new reference edge restarts the count.
- R7: When UP lasts at most N-1 cycles, `ref_fast` stays low. When UP lasts N cycles or more, `ref_fast` is high.
- R8: With equal reference and feedback periods and a phase offset shorter than the window, both flags stay low, whichever input leads.
- R9: A feedback far faster than the reference keeps `fb_fast` high most of the time with `ref_fast` low. A reference far faster than the feedback keeps `ref_fast` high most of the time with `fb_fast` low.
- R10: The flags are not sticky. They change only at their sample points, and a sample that finds the pulse low clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference clock, sampled as a level |
| fb_in | input | 1 | Feedback clock, sampled as a level |
| win | input | WIN_W | Lock-loss window in system cycles |
| up | output | 1 | Reference-leads pulse |
| dn | output | 1 | Feedback-leads pulse |
| ref_fast | output | 1 | Reference-too-fast flag |
| fb_fast | output | 1 | Feedback-too-fast flag |

## Verification
The bench uses the default 8-bit window width and drives the window at 0, 3 and 10 cycles against a fixed six-cycle UP pulse. This places the pulse on both sides of the window and also exercises the undelayed sampling point. The stimuli are equal periods with the reference leading, the feedback leading, and coincident edges. Further runs use a feedback eight times faster, a reference five times faster, and a mild 4:3 mismatch in which the feedback flag must toggle rather than stick.

// File: rtl/pfd_lockwatch.sv
module pfd_lockwatch #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic [WIN_W-1:0] win,
  output logic             up,
  output logic             dn,
  output logic             ref_fast,
  output logic             fb_fast
);

  localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

  logic [2:0]       ref_sh, fb_sh;
  logic             ref_rise, fb_rise;
  logic             up_nx, dn_nx, both;
  logic [WIN_W-1:0] cnt;
  logic             armed, tap;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_sh <= '0;
      fb_sh  <= '0;
    end else begin
      ref_sh <= {ref_sh[1:0], ref_in};
      fb_sh  <= {fb_sh[1:0], fb_in};
    end
  end

  assign ref_rise = ref_sh[1] & ~ref_sh[2];
  assign fb_rise  = fb_sh[1] & ~fb_sh[2];

  assign up_nx = up | ref_rise;
  assign dn_nx = dn | fb_rise;
  assign both  = up_nx & dn_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up_nx & ~both;
      dn <= dn_nx & ~both;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (ref_rise) begin
      cnt   <= win;
      armed <= (win != '0);
    end else if (armed) begin
      cnt <= cnt - ONE;
      if (cnt == ONE) armed <= 1'b0;
    end
  end

  assign tap = (win == '0) ? ref_rise : (armed && cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_fast <= 1'b0;
      fb_fast  <= 1'b0;
    end else begin
      if (tap)     ref_fast <= up;
      if (fb_rise) fb_fast  <= dn;
    end
  end

endmodule

// File: rtl/pfd_lockwatch_chk.sv
module pfd_lockwatch_chk (
  input logic clk,
  input logic rst,
  input logic up,
  input logic dn,
  input logic ref_fast,
  input logic fb_fast,
  input logic ref_rise,
  input logic fb_rise
);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!up && !dn && !ref_fast && !fb_fast)); // R1

  AST_UP_SET: assert property (@(posedge clk) disable iff (rst)
    (ref_rise && !fb_rise && !dn) |=> up); // R2

  AST_DN_SET: assert property (@(posedge clk) disable iff (rst)
    (fb_rise && !ref_rise && !up) |=> dn); // R2

  AST_NO_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(up && dn)); // R3

  AST_COINCIDE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ref_rise && fb_rise && !up && !dn) |=> (!up && !dn)); // R4

  AST_FB_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    fb_rise |=> (fb_fast == $past(dn))); // R5

  AST_FB_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fb_rise |=> $stable(fb_fast)); // R10

endmodule

bind pfd_lockwatch pfd_lockwatch_chk u_chk (
  .clk(clk), .rst(rst), .up(up), .dn(dn),
  .ref_fast(ref_fast), .fb_fast(fb_fast),
  .ref_rise(ref_rise), .fb_rise(fb_rise)
);

// File: tb/test_pfd_lockwatch.sv
module test_pfd_lockwatch;
  localparam int CLK_P = 10;
  localparam int WIN_W = 8;
  localparam int WARM  = 400;
  localparam int SPAN  = 1200;

  logic clk = 0, rst = 1, ref_in = 0, fb_in = 0;
  logic [WIN_W-1:0] win = 8'd10;
  logic up, dn, ref_fast, fb_fast;

  pfd_lockwatch #(.WIN_W(WIN_W)) i_pfd_lockwatch (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in), .win(win),
    .up(up), .dn(dn), .ref_fast(ref_fast), .fb_fast(fb_fast));

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stimulus generator
  bit gen_on = 0;
  int ref_per = 40, fb_per = 40, fb_off = 0, cyc = 0;
  always @(negedge clk) if (gen_on) begin
    cyc++;
    ref_in <= (cyc % ref_per) < ref_per/2;
    fb_in  <= ((cyc + fb_per*1000 - fb_off) % fb_per) < fb_per/2;
  end

  // scoreboard: 0 never, 1 seen, 2 mostly, 3 toggles
  typedef struct {
    string req;
    int ref_lvl, fb_lvl, up_run, dn_run;
  } exp_t;
  exp_t q[$];
  event win_done;
  bit mon_on = 0;
  int ref_cnt, fb_cnt, up_cur, dn_cur, up_max, dn_max;

  always @(negedge clk) if (mon_on) begin
    ref_cnt += ref_fast;
    fb_cnt  += fb_fast;
    up_cur = up ? up_cur + 1 : 0;
    dn_cur = dn ? dn_cur + 1 : 0;
    if (up_cur > up_max) up_max = up_cur;
    if (dn_cur > dn_max) dn_max = dn_cur;
  end

  function automatic bit lvl_ok(int cnt, int lvl);
    case (lvl)
      0: return cnt == 0;
      1: return cnt > 0;
      2: return cnt >= (SPAN*3)/4;
      default: return cnt > 0 && cnt < SPAN;
    endcase
  endfunction

  initial forever begin
    exp_t e;
    @(win_done);
    e = q.pop_front();
    chk(lvl_ok(ref_cnt, e.ref_lvl), {e.req, " ref_fast level"}, ref_cnt, e.ref_lvl);
    chk(lvl_ok(fb_cnt, e.fb_lvl), {e.req, " fb_fast level"}, fb_cnt, e.fb_lvl);
    if (e.up_run >= 0) chk(up_max == e.up_run, {e.req, " up width"}, up_max, e.up_run);
    if (e.dn_run >= 0) chk(dn_max == e.dn_run, {e.req, " dn width"}, dn_max, e.dn_run);
    ref_cnt = 0; fb_cnt = 0; up_cur = 0; dn_cur = 0; up_max = 0; dn_max = 0;
  end

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic run_case(input string req, input int rp, input int fp, input int off,
                          input int w, input int rl, input int fl, input int ur, input int dr);
    exp_t e;
    e.req = req; e.ref_lvl = rl; e.fb_lvl = fl; e.up_run = ur; e.dn_run = dr;
    q.push_back(e);
    gen_on = 0;
    @(negedge clk);
    ref_per = rp; fb_per = fp; fb_off = off; cyc = 0; win = WIN_W'(w);
    ref_in = 0; fb_in = 0;
    do_reset();
    gen_on = 1;
    repeat (WARM) @(negedge clk);
    mon_on = 1;
    repeat (SPAN) @(negedge clk);
    mon_on = 0;
    ->win_done;
    @(negedge clk);
  endtask

  initial begin
    ref_cnt = 0; fb_cnt = 0; up_cur = 0; dn_cur = 0; up_max = 0; dn_max = 0;
    do_reset();
    chk({up, dn, ref_fast, fb_fast} == 4'b0, "R1 reset state", {up, dn, ref_fast, fb_fast}, 0);

    // R2 latency and R3 common clear
    ref_in = 1;
    repeat (2) @(negedge clk);
    chk(up == 0, "R2 up before third edge", up, 0);
    @(negedge clk);
    chk(up == 1, "R2 up at third edge", up, 1);
    fb_in = 1;
    repeat (2) @(negedge clk);
    chk(up == 1 && dn == 0, "R3 up held until fb edge seen", {up, dn}, 2);
    @(negedge clk);
    chk(up == 0 && dn == 0, "R3 both cleared together", {up, dn}, 0);

    run_case("R7 R8 ref leads 6, win 10", 40, 40, 6, 10, 0, 0, 6, 0);
    run_case("R7 R6 ref leads 6, win 3", 40, 40, 6, 3, 2, 0, 6, 0);
    run_case("R6 ref leads 6, win 0", 40, 40, 6, 0, 0, 0, 6, 0);
    run_case("R8 fb leads 5, win 10", 40, 40, -5, 10, 0, 0, 0, 5);
    run_case("R4 coincident edges", 40, 40, 0, 10, 0, 0, 0, 0);
    run_case("R9 R5 fb far faster", 64, 8, 3, 10, 0, 2, -1, -1);
    run_case("R9 ref far faster", 20, 100, 10, 3, 2, 0, -1, -1);
    run_case("R10 mild fb mismatch", 40, 30, 7, 10, 0, 3, -1, -1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P*200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule